// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block collects every interrupt source of a UART channel into one interrupt line. From the receive and transmit FIFO fill counts and two programmable trigger levels it forms a live status word that always reflects the FIFO state right now. Each clock, the level-type flags of that word and the one-cycle error event pulses are folded into a sticky status register. Software acknowledges sticky bits by writing ones to them.

A set-only and a clear-only register form the interrupt mask, so there is no read-modify-write race between independent drivers. The interrupt output is the registered OR of the masked sticky bits. A small synchronous register bus reaches the mask, the sticky register, the live word and the two trigger levels. The FIFOs, the serial framing and the baud generator sit outside this block. They supply the fill counts and the event pulses.

Top module: `uart_irq_agg`

## Requirements
- R1: The live status word has bit 0 = RX count >= RX trigger level, bit 1 = RX count is 0, bit 2 = RX count equals DEPTH, bit 3 = TX count is 0, bit 4 = TX count equals DEPTH. It is combinational from the counts and levels, appears on `live_status`, and reads at bus address 4.
- R2: The TX trigger flag (TX count >= TX trigger level) is bit 13 of the live word. In the sticky register the same condition sets bit 10.
- R3: On every clock edge out of reset, live bits 0..4 are ORed into sticky bits 0..4, and live bit 13 is ORed into sticky bit 10.
- R4: Event pulses set sticky bits at the next edge: RX overrun bit 5, framing error bit 6, parity error bit 7, RX timeout bit 8, modem change bit 9, TX overrun bit 12. Sticky bits 11 and 13..15 stay 0.
- R5: A bus write to address 3 clears every sticky bit written as 1 and leaves the others unchanged. The sticky register reads at address 3 and appears on `sticky_status`.
- R6: If a clear and a set (event or live flag) hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A write to address 0 ORs the data into the 16-bit mask. A write to address 1 clears the written bits from the mask. A write to address 2 (where the mask reads) has no effect.
- R8: `irq` is a register loaded each clock with the OR of (mask AND sticky), so it follows the mask and sticky registers one clock later.
- R9: Synchronous active-low reset clears the mask, the sticky register and `irq`, and sets both trigger levels to 0x20.
- R10: A write to address 5 (RX) or 6 (TX) loads the low CNT_W bits of the data into the trigger level. The level reads back at that address, zero-extended.
- R11: Address 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO fill count (0..DEPTH) |
| tx_count | input | CNT_W | Transmit FIFO fill count (0..DEPTH) |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem_chg | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| live_status | output | 16 | Live FIFO status word |
| sticky_status | output | 16 | Sticky interrupt status register |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle: each event pulse lands in its sticky bit, a set sticky bit stays set until it is written with a one, an event beats a simultaneous clear, the live flags fold into the sticky register, mask set, clear and hold follow the bus, trigger-level writes land, and `irq` tracks the masked sticky state with a one-cycle lag. Other behaviour only the bench scenarios can show. This covers the exact bit positions of the live word at the FIFO boundaries (empty, full, exactly at and one below the trigger level), the reset values read over the bus, writes to the read-only mask address and the unmapped address, and long random mixes of counts, events and bus writes compared against an independent model.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants, bit positions and register addresses of the
// UART interrupt status aggregator.
// Assumes: a 16-bit register data path and a 3-bit register address.
package uart_irq_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int N_EVT  = 6;
    localparam int N_FOLD = 6;

    // Live status word bit positions (decoded by software)
    localparam int LV_RX_TRIG  = 0;
    localparam int LV_RX_EMPTY = 1;
    localparam int LV_RX_FULL  = 2;
    localparam int LV_TX_EMPTY = 3;
    localparam int LV_TX_FULL  = 4;
    localparam int LV_TX_TRIG  = 13;

    // Sticky register bit position of the TX trigger flag
    localparam int ST_TX_TRIG  = 10;

    // Register map
    typedef enum logic [ADDR_W-1:0] {
        A_MASK_SET = 3'd0,
        A_MASK_CLR = 3'd1,
        A_MASK     = 3'd2,
        A_STICKY   = 3'd3,
        A_LIVE     = 3'd4,
        A_RX_LVL   = 3'd5,
        A_TX_LVL   = 3'd6,
        A_NONE     = 3'd7
    } reg_addr_e;

    // Sticky bit position of event input e (0 = RX overrun .. 5 = TX overrun)
    function automatic int evt_pos(input int e);
        case (e)
            0:       return 5;   // RX overrun
            1:       return 6;   // framing error
            2:       return 7;   // parity error
            3:       return 8;   // RX timeout
            4:       return 9;   // modem status change
            default: return 12;  // TX overrun
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_flags.sv
// Module: uart_fifo_flags
// Derives empty, full and at-trigger flags for one FIFO from its fill count.
// Assumes: count never exceeds DEPTH; the trigger level may hold any value.
module uart_fifo_flags #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             at_trig
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Purpose: compare the fill count against the fixed bounds and the level
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        at_trig = (count >= level);
    end

    // R1: the fill count supplied by the FIFO stays within its depth
    p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/uart_live_status.sv
// Module: uart_live_status
// Builds the live FIFO status word from the RX and TX fill counts and levels.
// Assumes: both FIFOs have the same depth; the word is purely combinational.
module uart_live_status
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    output logic [DATA_W-1:0] live
);

    logic [CNT_W-1:0] cnt_a [2];
    logic [CNT_W-1:0] lvl_a [2];
    logic [1:0]       empty_a;
    logic [1:0]       full_a;
    logic [1:0]       trig_a;

    // Purpose: index 0 is the receive side, index 1 the transmit side
    always_comb begin
        cnt_a[0] = rx_count;
        cnt_a[1] = tx_count;
        lvl_a[0] = rx_level;
        lvl_a[1] = tx_level;
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        uart_fifo_flags #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (cnt_a[g]),
            .level   (lvl_a[g]),
            .empty   (empty_a[g]),
            .full    (full_a[g]),
            .at_trig (trig_a[g])
        );
    end

    // Purpose: place each flag at its software-visible bit position
    always_comb begin
        live              = '0;
        live[LV_RX_TRIG]  = trig_a[0];
        live[LV_RX_EMPTY] = empty_a[0];
        live[LV_RX_FULL]  = full_a[0];
        live[LV_TX_EMPTY] = empty_a[1];
        live[LV_TX_FULL]  = full_a[1];
        live[LV_TX_TRIG]  = trig_a[1];
    end

endmodule

// File: rtl/uart_sticky_status.sv
// Module: uart_sticky_status
// Holds the sticky interrupt status: live flags and event pulses set bits,
// bus writes of ones clear bits, and a set beats a clear in the same cycle.
// Assumes: fold[4:0] are live bits 0..4, fold[5] is the live TX trigger flag.
module uart_sticky_status
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FOLD-1:0] fold,
    input  logic [N_EVT-1:0]  evt,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] sticky
);

    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] sticky_q;

    // Purpose: gather every source that sets a sticky bit this cycle
    always_comb begin
        set_vec             = '0;
        set_vec[4:0]        = fold[4:0];
        set_vec[ST_TX_TRIG] = fold[5];
        for (int e = 0; e < N_EVT; e++) begin
            set_vec[evt_pos(e)] = evt[e];
        end
    end

    // Purpose: bits the bus asks to clear this cycle
    always_comb clr_vec = clr_en ? clr_bits : '0;

    // Purpose: sticky register update, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (sticky_q & ~clr_vec) | set_vec;
        end
    end

    assign sticky = sticky_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_hold_chk
        // R5: a set bit survives any cycle in which it is not written with 1
        p_hold_unless_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q[b] && !(clr_en && clr_bits[b])) |=> sticky_q[b]);
    end

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt_chk
        // R4: an event pulse shows in its sticky bit at the next edge
        p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            evt[e] |=> sticky_q[evt_pos(e)]);
        // R6: event and write-1-to-clear together leave the bit set
        p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[e] && clr_en && clr_bits[evt_pos(e)]) |=> sticky_q[evt_pos(e)]);
        // R5: a written 1 with no event present clears the bit
        p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_bits[evt_pos(e)] && !evt[e]) |=> !sticky_q[evt_pos(e)]);
    end

    for (genvar f = 0; f < 5; f++) begin : g_fold_chk
        // R3: a live flag is in the sticky register after the next edge
        p_live_folds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fold[f] |=> sticky_q[f]);
    end

    // R2: live TX trigger (bit 13) lands in sticky bit 10
    p_tx_trig_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fold[5] |=> sticky_q[ST_TX_TRIG]);

    // R4: unused sticky positions never become set
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sticky_q[11] == 1'b0 && sticky_q[15:13] == 3'b000));

endmodule

// File: rtl/uart_irq_mask.sv
// Module: uart_irq_mask
// Interrupt mask changed only through a set-strobe and a clear-strobe.
// Assumes: at most one of the strobes is active in a cycle.
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask
);

    logic [DATA_W-1:0] mask_q;

    // Purpose: OR in on set, AND out on clear, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_en) begin
            mask_q <= mask_q | wdata;
        end else if (clr_en) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    assign mask = mask_q;

    // R7: after a set write every written bit is enabled
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(wdata)) == $past(wdata)));
    // R7: after a clear write every written bit is disabled
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0));
    // R7: with no strobe the mask holds
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/uart_irq_agg.sv
// Module: uart_irq_agg (top)
// UART interrupt status aggregator: register decode, trigger levels, live
// status, sticky status, mask and the registered interrupt line.
// Assumes: one bus access per cycle; reads are combinational from bus_addr.
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CNT_W      = $clog2(DEPTH + 1),
    parameter int TRIG_RESET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_modem_chg,
    input  logic              ev_tx_overrun,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] live_status,
    output logic [DATA_W-1:0] sticky_status,
    output logic              irq
);

    localparam logic [CNT_W-1:0] LVL_RST = CNT_W'(TRIG_RESET);
    localparam int               PAD_W   = DATA_W - CNT_W;

    reg_addr_e         addr_e;
    logic              wr_mask_set;
    logic              wr_mask_clr;
    logic              wr_sticky;
    logic              wr_rx_lvl;
    logic              wr_tx_lvl;
    logic [CNT_W-1:0]  rx_lvl_q;
    logic [CNT_W-1:0]  tx_lvl_q;
    logic [DATA_W-1:0] live_w;
    logic [DATA_W-1:0] sticky_w;
    logic [DATA_W-1:0] mask_w;
    logic [N_EVT-1:0]  evt_w;
    logic [N_FOLD-1:0] fold_w;
    logic              irq_q;

    // Purpose: decode the write strobes of each register
    always_comb begin
        addr_e      = reg_addr_e'(bus_addr);
        wr_mask_set = bus_wr && (addr_e == A_MASK_SET);
        wr_mask_clr = bus_wr && (addr_e == A_MASK_CLR);
        wr_sticky   = bus_wr && (addr_e == A_STICKY);
        wr_rx_lvl   = bus_wr && (addr_e == A_RX_LVL);
        wr_tx_lvl   = bus_wr && (addr_e == A_TX_LVL);
    end

    // Purpose: programmable trigger level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_lvl_q <= LVL_RST;
            tx_lvl_q <= LVL_RST;
        end else begin
            if (wr_rx_lvl) rx_lvl_q <= bus_wdata[CNT_W-1:0];
            if (wr_tx_lvl) tx_lvl_q <= bus_wdata[CNT_W-1:0];
        end
    end

    uart_live_status #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_level (rx_lvl_q),
        .tx_level (tx_lvl_q),
        .live     (live_w)
    );

    // Purpose: pack the event pulses and the foldable live flags
    always_comb begin
        evt_w  = {ev_tx_overrun, ev_modem_chg, ev_rx_timeout,
                  ev_parity_err, ev_frame_err, ev_rx_overrun};
        fold_w = {live_w[LV_TX_TRIG], live_w[4:0]};
    end

    uart_sticky_status u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .fold     (fold_w),
        .evt      (evt_w),
        .clr_en   (wr_sticky),
        .clr_bits (bus_wdata),
        .sticky   (sticky_w)
    );

    uart_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_mask_set),
        .clr_en (wr_mask_clr),
        .wdata  (bus_wdata),
        .mask   (mask_w)
    );

    // Purpose: registered interrupt line from masked sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(mask_w & sticky_w);
        end
    end

    // Purpose: read multiplexer over the register map
    always_comb begin
        case (addr_e)
            A_MASK:   bus_rdata = mask_w;
            A_STICKY: bus_rdata = sticky_w;
            A_LIVE:   bus_rdata = live_w;
            A_RX_LVL: bus_rdata = {{PAD_W{1'b0}}, rx_lvl_q};
            A_TX_LVL: bus_rdata = {{PAD_W{1'b0}}, tx_lvl_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign live_status   = live_w;
    assign sticky_status = sticky_w;
    assign irq           = irq_q;

    // R8: a masked pending bit raises the interrupt one clock later
    p_irq_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mask_w & sticky_w)) |=> irq_q);
    // R8: with nothing masked-pending the interrupt drops one clock later
    p_irq_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(mask_w & sticky_w)) |=> !irq_q);
    // R10: a level write is visible at the next edge
    p_rx_level_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rx_lvl |=> (rx_lvl_q == $past(bus_wdata[CNT_W-1:0])));
    p_tx_level_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_lvl |=> (tx_lvl_q == $past(bus_wdata[CNT_W-1:0])));
    // R11: a write to the unmapped address leaves the levels unchanged
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr_e == A_NONE) |=> ($stable(rx_lvl_q) && $stable(tx_lvl_q)));

endmodule

// File: tb/uart_irq_agg_test.sv
// Bench: directed corner cases then seeded random traffic, checked against
// an independent model of the register behaviour.
module uart_irq_agg_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int N_RANDOM   = 3000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] tx_count = '0;
    logic [5:0]       ev = '0;   // 0 rx ovr,1 frame,2 parity,3 timeout,4 modem,5 tx ovr
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [15:0]      bus_wdata = '0;
    logic [15:0]      bus_rdata;
    logic [15:0]      live_status;
    logic [15:0]      sticky_status;
    logic             irq;

    int n_checks = 0;
    int n_fails  = 0;

    // Model state
    logic [15:0]      m_mask, m_sticky;
    logic             m_irq;
    logic [CNT_W-1:0] m_rxl, m_txl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_agg #(.DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .ev_rx_overrun (ev[0]),
        .ev_frame_err  (ev[1]),
        .ev_parity_err (ev[2]),
        .ev_rx_timeout (ev[3]),
        .ev_modem_chg  (ev[4]),
        .ev_tx_overrun (ev[5]),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .live_status   (live_status),
        .sticky_status (sticky_status),
        .irq           (irq)
    );

    function automatic logic [15:0] exp_live(input logic [CNT_W-1:0] rc, tc, rl, tl);
        logic [15:0] v = '0;
        v[0]  = (rc >= rl);
        v[1]  = (rc == 0);
        v[2]  = (rc == DEPTH);
        v[3]  = (tc == 0);
        v[4]  = (tc == DEPTH);
        v[13] = (tc >= tl);
        return v;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd2:    return m_mask;
            3'd3:    return m_sticky;
            3'd4:    return exp_live(rx_count, tx_count, m_rxl, m_txl);
            3'd5:    return 16'(m_rxl);
            3'd6:    return 16'(m_txl);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One clock: inputs already driven just after a falling edge
    task automatic cycle();
        logic [15:0]      lv, setv, clrv, n_sticky, n_mask;
        logic [CNT_W-1:0] n_rxl, n_txl;
        logic             n_irq;
        #1;
        lv = exp_live(rx_count, tx_count, m_rxl, m_txl);
        check("R1 R2 live_status", live_status, lv);
        check("R1 R5 R7 R10 R11 bus_rdata", bus_rdata, exp_rdata(bus_addr));
        setv = {3'b000, ev[5], 1'b0, lv[13], ev[4], ev[3], ev[2], ev[1], ev[0], lv[4:0]};
        clrv = (bus_wr && bus_addr == 3'd3) ? bus_wdata : 16'h0;
        n_sticky = (m_sticky & ~clrv) | setv;
        n_mask = m_mask;
        if (bus_wr && bus_addr == 3'd0) n_mask = m_mask | bus_wdata;
        if (bus_wr && bus_addr == 3'd1) n_mask = m_mask & ~bus_wdata;
        n_rxl = (bus_wr && bus_addr == 3'd5) ? bus_wdata[CNT_W-1:0] : m_rxl;
        n_txl = (bus_wr && bus_addr == 3'd6) ? bus_wdata[CNT_W-1:0] : m_txl;
        n_irq = |(m_mask & m_sticky);
        @(posedge clk);
        m_sticky = n_sticky; m_mask = n_mask; m_irq = n_irq;
        m_rxl = n_rxl; m_txl = n_txl;
        @(negedge clk);
        check("R3 R4 R5 R6 sticky_status", sticky_status, m_sticky);
        check("R7 mask", uut.u_mask.mask, m_mask);
        check("R8 irq", {15'h0, irq}, {15'h0, m_irq});
        bus_wr = 1'b0;
        ev = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    function automatic logic [CNT_W-1:0] pick_count(input logic [CNT_W-1:0] lvl);
        int v;
        case ($urandom % 5)
            0:       v = 0;
            1:       v = DEPTH;
            2:       v = int'(lvl);
            3:       v = int'(lvl) - 1;
            default: v = int'($urandom % (DEPTH + 1));
        endcase
        if (v < 0) v = 0;
        if (v > DEPTH) v = DEPTH;
        return CNT_W'(v);
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17));
        m_mask = '0; m_sticky = '0; m_irq = 1'b0; m_rxl = 7'd32; m_txl = 7'd32;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 sticky at reset", sticky_status, 16'h0000);
        check("R9 irq at reset", {15'h0, irq}, 16'h0000);
        bus_addr = 3'd2; #1;
        check("R9 mask at reset", bus_rdata, 16'h0000);
        bus_addr = 3'd5; #1;
        check("R9 RX level at reset", bus_rdata, 16'h0020);
        bus_addr = 3'd6; #1;
        check("R9 TX level at reset", bus_rdata, 16'h0020);
        rst_n = 1'b1;

        // R1 / R3: empty FIFOs
        #1 check("R1 live empty", live_status, 16'h000A);
        cycle();
        check("R3 sticky after empty", sticky_status, 16'h000A);

        // R1 / R2: both exactly at trigger level
        rx_count = 7'd32; tx_count = 7'd32;
        #1 check("R2 live at triggers", live_status, 16'h2001);
        cycle();
        check("R2 R3 sticky TX trigger at bit 10", sticky_status, 16'h040B);

        // R1: one below trigger levels
        rx_count = 7'd31; tx_count = 7'd31;
        #1 check("R1 live below triggers", live_status, 16'h0000);
        cycle();

        // R1: full
        rx_count = 7'd64; tx_count = 7'd64;
        #1 check("R1 live full", live_status, 16'h2015);
        cycle();

        // R6: clear all while a framing event arrives
        wr(3'd3, 16'hFFFF); ev[1] = 1'b1;
        cycle();
        check("R6 event beats clear", sticky_status, 16'h0455);

        // R5: clear with quiet inputs
        rx_count = 7'd10; tx_count = 7'd10;
        wr(3'd3, 16'hFFFF);
        cycle();
        check("R5 clear all", sticky_status, 16'h0000);

        // R7: mask register address ignores writes
        wr(3'd2, 16'hFFFF);
        cycle();
        bus_addr = 3'd2; #1;
        check("R7 mask write ignored", bus_rdata, 16'h0000);
        wr(3'd0, 16'h0080);
        cycle();
        bus_addr = 3'd2; #1;
        check("R7 mask set", bus_rdata, 16'h0080);

        // R8: parity event raises irq one clock after sticky
        ev[2] = 1'b1;
        cycle();
        check("R4 parity bit 7", sticky_status, 16'h0080);
        check("R8 irq lags sticky", {15'h0, irq}, 16'h0000);
        cycle();
        check("R8 irq raised", {15'h0, irq}, 16'h0001);
        wr(3'd1, 16'h0080);
        cycle();
        check("R8 irq still high one clock after mask clear", {15'h0, irq}, 16'h0001);
        cycle();
        check("R8 irq dropped", {15'h0, irq}, 16'h0000);

        // R4: remaining events
        ev = 6'b111001;
        cycle();
        check("R4 events 5 8 9 12", sticky_status, 16'h13A0);

        // R10: RX level write and compare
        wr(3'd5, 16'hFF05);
        cycle();
        rx_count = 7'd5; bus_addr = 3'd5;
        #1 check("R10 RX level readback", bus_rdata, 16'h0005);
        check("R10 live uses new level", live_status, 16'h0001);
        cycle();

        // R11: unmapped address
        wr(3'd7, 16'hFFFF);
        cycle();
        bus_addr = 3'd7; #1;
        check("R11 unmapped reads zero", bus_rdata, 16'h0000);
        bus_addr = 3'd6; #1;
        check("R11 TX level unchanged", bus_rdata, 16'h0020);

        // Random traffic
        for (int i = 0; i < N_RANDOM; i++) begin
            rx_count = pick_count(m_rxl);
            tx_count = pick_count(m_txl);
            for (int e = 0; e < 6; e++) ev[e] = (($urandom % 8) == 0);
            bus_addr = 3'($urandom % 8);
            bus_wdata = 16'($urandom);
            bus_wr = (($urandom % 3) == 0);
            if (bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd6))
                bus_wdata = 16'($urandom % (DEPTH + 1));
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule